// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a byte-addressed serial memory that sits on a two-wire bus. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions and shifts bytes in and out. It matches the device address against a fixed code plus three strap inputs and answers each accepted byte by pulling the data line low through an open-drain output enable.

Writes load a word address from two bytes. Each data byte is then handed to the memory array as a single-cycle write strobe. A pulse is raised at the closing stop so that a neighbouring page-write block can start the nonvolatile commit. While that neighbour reports busy, the engine stays silent on the bus. This lets the master poll with its address until the engine acknowledges again.

Reads are served from the same persistent word pointer. That pointer wraps inside a page while writing and across the whole array while reading.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the data output enable is released, no write strobe or commit pulse is raised, and the word pointer is 0.
- R2: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. A start in any state, even partway through a byte, abandons the transfer and begins a new device-address reception.
- R3: The device byte is received most significant bit first: bits 7..4 must equal 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 selects read (1) or write (0). On a match the data line is held low for the ninth clock. On a mismatch nothing is acknowledged.
- R4: A write header carries two word-address bytes, high byte first. The pointer takes the low ADDR_W bits of {high, low}, so the upper 16-ADDR_W bits of the high byte are ignored.
- R5: Each write data byte is acknowledged and strobed for one cycle on `mem_we_o` with the current pointer and the byte. After the byte, the low PAGE_W pointer bits increment and wrap inside the page while the upper bits stay fixed.
- R6: A read without a preceding address returns the byte at the last accessed location plus one, and the pointer is kept between transactions.
- R7: A write header with no data, then a repeated start and a read header, returns the byte at the loaded address.
- R8: A read continues while the master acknowledges each byte. The pointer advances and wraps from the last array location to 0. A master not-acknowledge ends the read with the data line released.
- R9: While `busy_i` is high, the engine acknowledges nothing, not even its own address, and strobes no write. Once `busy_i` falls, its address is acknowledged again.
- R10: `commit_o` pulses for one cycle at a stop that follows at least one written data byte in the same transfer. A header with no data raises no pulse.
- R11: The data output enable only changes while the bus clock is low. An acknowledge is released shortly after the falling clock edge that ends the ninth clock.
- R12: After a rejected device byte, the engine ignores the bus until the next start, so it acknowledges no further bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 3 | Device select straps compared with device byte bits 3..1 |
| busy_i | input | 1 | Nonvolatile commit in progress from the page-write neighbour |
| mem_addr_o | output | ADDR_W | Word pointer, used as both read and write address |
| mem_rdata_i | input | 8 | Array data at `mem_addr_o`, read combinationally |
| mem_we_o | output | 1 | One-cycle write strobe for a received byte |
| mem_wdata_o | output | 8 | Byte written when `mem_we_o` is high |
| commit_o | output | 1 | One-cycle pulse at the stop that closes a write |

## Verification
The bench builds the engine with ADDR_W = 10 and PAGE_W = 3, which gives a 1024-byte array made of 8-byte pages. With these values, page wrap-around is reached after a few data bytes, and the wrap from the top of the array to location 0 is reached from address 0x3FE. The high word-address byte then has six ignored bits, so the bench sends 0xFE there to show they have no effect. The bench bus model combines the master's data with the engine's open-drain enable, so every acknowledge and read bit is observed on the wired line itself.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } link_state_e;

endpackage

// File: rtl/tw_bus_sampler.sv
module tw_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d       = smp_q;
        smp_d.scl_m = scl_i;
        smp_d.scl_s = smp_q.scl_m;
        smp_d.scl_p = smp_q.scl_s;
        smp_d.sda_m = sda_i;
        smp_d.sda_s = smp_q.sda_m;
        smp_d.sda_p = smp_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_o      = smp_q.scl_s;
    assign sda_o      = smp_q.sda_s;
    assign scl_rise_o = smp_q.scl_s & ~smp_q.scl_p;
    assign scl_fall_o = ~smp_q.scl_s & smp_q.scl_p;
    assign start_o    = smp_q.scl_s & smp_q.scl_p & smp_q.sda_p & ~smp_q.sda_s;
    assign stop_o     = smp_q.scl_s & smp_q.scl_p & ~smp_q.sda_p & smp_q.sda_s;

endmodule

// File: rtl/tw_byte_shifter.sv
module tw_byte_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en_i,
    input  logic             in_bit_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             out_en_i,
    output logic [WIDTH-1:0] byte_o
);

    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)        sh_d = load_val_i;
        else if (in_en_i)  sh_d = {sh_q[WIDTH-2:0], in_bit_i};
        else if (out_en_i) sh_d = {sh_q[WIDTH-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign byte_o = sh_q;

endmodule

// File: rtl/tw_word_ptr.sv
module tw_word_ptr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_page_i,
    input  logic              inc_full_i,
    output logic [ADDR_W-1:0] ptr_o
);

    logic [ADDR_W-1:0] ptr_d, ptr_q;
    logic [PAGE_W-1:0] col_next;

    assign col_next = ptr_q[PAGE_W-1:0] + PAGE_W'(1);

    always_comb begin
        ptr_d = ptr_q;
        if (load_i)          ptr_d = load_val_i;
        else if (inc_full_i) ptr_d = ptr_q + ADDR_W'(1);
        else if (inc_page_i) ptr_d = {ptr_q[ADDR_W-1:PAGE_W], col_next};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import serial_mem_pkg::*;
#(
    parameter int          ADDR_W   = 13,
    parameter int          PAGE_W   = 5,
    parameter logic [3:0]  DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    output logic              commit_o
);

    localparam int HI_W  = ADDR_W - BYTE_BITS;
    localparam int CNT_W = $clog2(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    typedef struct packed {
        link_state_e       state;
        logic [CNT_W-1:0]  bitcnt;
        logic              full;
        logic              rw;
        logic [HI_W-1:0]   hi;
        logic              oe;
        logic              we;
        logic [7:0]        wdata;
        logic              commit;
        logic              wrote;
        logic              mack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // sampled bus and events
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    // shifter controls
    logic       sh_in_en, sh_load, sh_out_en;
    logic [7:0] sh_byte;

    // pointer controls
    logic              p_load, p_inc_page, p_inc_full;
    logic [ADDR_W-1:0] ptr;

    logic dev_hit, rx_state, st_idle, st_dev_ack;

    tw_bus_sampler u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    tw_byte_shifter #(.WIDTH(BYTE_BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_en_i    (sh_in_en),
        .in_bit_i   (sda_s),
        .load_i     (sh_load),
        .load_val_i (mem_rdata_i),
        .out_en_i   (sh_out_en),
        .byte_o     (sh_byte)
    );

    tw_word_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (p_load),
        .load_val_i ({ctl_q.hi, sh_byte}),
        .inc_page_i (p_inc_page),
        .inc_full_i (p_inc_full),
        .ptr_o      (ptr)
    );

    assign dev_hit  = (sh_byte[7:4] == DEV_CODE) && (sh_byte[3:1] == strap_i);
    assign rx_state = (ctl_q.state == ST_DEV) || (ctl_q.state == ST_AHI) ||
                      (ctl_q.state == ST_ALO) || (ctl_q.state == ST_WDAT);

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.we     = 1'b0;
        ctl_d.commit = 1'b0;
        sh_in_en     = 1'b0;
        sh_load      = 1'b0;
        sh_out_en    = 1'b0;
        p_load       = 1'b0;
        p_inc_page   = 1'b0;
        p_inc_full   = 1'b0;

        if (start_ev) begin
            ctl_d.state  = busy_i ? ST_IDLE : ST_DEV;
            ctl_d.bitcnt = '0;
            ctl_d.full   = 1'b0;
            ctl_d.oe     = 1'b0;
            ctl_d.wrote  = 1'b0;
        end else if (stop_ev) begin
            ctl_d.commit = ctl_q.wrote;
            ctl_d.wrote  = 1'b0;
            ctl_d.state  = ST_IDLE;
            ctl_d.oe     = 1'b0;
        end else if (rx_state) begin
            if (scl_rise && !ctl_q.full) begin
                sh_in_en     = 1'b1;
                ctl_d.bitcnt = ctl_q.bitcnt + CNT_W'(1);
                if (ctl_q.bitcnt == LAST_BIT) ctl_d.full = 1'b1;
            end
            if (scl_fall && ctl_q.full) begin
                ctl_d.full   = 1'b0;
                ctl_d.bitcnt = '0;
                unique case (ctl_q.state)
                    ST_DEV: begin
                        if (dev_hit && !busy_i) begin
                            ctl_d.oe    = 1'b1;
                            ctl_d.rw    = sh_byte[0];
                            ctl_d.state = ST_DEV_ACK;
                        end else begin
                            ctl_d.state = ST_IDLE;
                        end
                    end
                    ST_AHI: begin
                        ctl_d.hi    = sh_byte[HI_W-1:0];
                        ctl_d.oe    = 1'b1;
                        ctl_d.state = ST_AHI_ACK;
                    end
                    ST_ALO: begin
                        p_load      = 1'b1;
                        ctl_d.oe    = 1'b1;
                        ctl_d.state = ST_ALO_ACK;
                    end
                    default: begin
                        ctl_d.we    = 1'b1;
                        ctl_d.wdata = sh_byte;
                        ctl_d.wrote = 1'b1;
                        ctl_d.oe    = 1'b1;
                        ctl_d.state = ST_WDAT_ACK;
                    end
                endcase
            end
        end else begin
            unique case (ctl_q.state)
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (ctl_q.rw) begin
                            sh_load      = 1'b1;
                            p_inc_full   = 1'b1;
                            ctl_d.oe     = ~mem_rdata_i[7];
                            ctl_d.bitcnt = '0;
                            ctl_d.state  = ST_RDAT;
                        end else begin
                            ctl_d.oe    = 1'b0;
                            ctl_d.state = ST_AHI;
                        end
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        ctl_d.oe    = 1'b0;
                        ctl_d.state = ST_ALO;
                    end
                end
                ST_ALO_ACK: begin
                    if (scl_fall) begin
                        ctl_d.oe    = 1'b0;
                        ctl_d.state = ST_WDAT;
                    end
                end
                ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        ctl_d.oe    = 1'b0;
                        p_inc_page  = 1'b1;
                        ctl_d.state = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (ctl_q.bitcnt == LAST_BIT) begin
                            ctl_d.oe    = 1'b0;
                            ctl_d.state = ST_RACK;
                        end else begin
                            sh_out_en    = 1'b1;
                            ctl_d.oe     = ~sh_byte[6];
                            ctl_d.bitcnt = ctl_q.bitcnt + CNT_W'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) ctl_d.mack = ~sda_s;
                    if (scl_fall) begin
                        if (ctl_q.mack) begin
                            sh_load      = 1'b1;
                            p_inc_full   = 1'b1;
                            ctl_d.oe     = ~mem_rdata_i[7];
                            ctl_d.bitcnt = '0;
                            ctl_d.state  = ST_RDAT;
                        end else begin
                            ctl_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign st_idle     = (ctl_q.state == ST_IDLE);
    assign st_dev_ack  = (ctl_q.state == ST_DEV_ACK);
    assign sda_oe_o    = ctl_q.oe;
    assign mem_addr_o  = ptr;
    assign mem_we_o    = ctl_q.we;
    assign mem_wdata_o = ctl_q.wdata;
    assign commit_o    = ctl_q.commit;

endmodule

// File: rtl/serial_mem_slave_chk.sv
module serial_mem_slave_chk #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              busy,
    input logic              in_idle,
    input logic              in_devack,
    input logic              mem_we,
    input logic              commit,
    input logic              stop_ev,
    input logic              inc_page,
    input logic              inc_full,
    input logic [ADDR_W-1:0] ptr
);

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R9
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && in_devack) |-> !$past(busy));

    // R5
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R8
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full && (ptr == {ADDR_W{1'b1}})) |=> (ptr == '0));

    // R10
    commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_ev));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> !sda_oe);

endmodule

bind serial_mem_slave serial_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .scl_s     (scl_s),
    .busy      (busy_i),
    .in_idle   (st_idle),
    .in_devack (st_dev_ack),
    .mem_we    (mem_we_o),
    .commit    (commit_o),
    .stop_ev   (stop_ev),
    .inc_page  (p_inc_page),
    .inc_full  (p_inc_full),
    .ptr       (ptr)
);

// File: tb/serial_mem_slave_bench.sv
`timescale 1ns/1ps
module serial_mem_slave_bench;

    localparam int AW = 10;
    localparam int PW = 3;
    localparam int H  = 6;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic          commit;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wlog [16];
    int wcnt = 0;
    int ccnt = 0;
    int oe_viol = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic oe_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign mem_rdata = mem[mem_addr];

    serial_mem_slave #(.ADDR_W(AW), .PAGE_W(PW)) u_serial_mem_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .strap_i     (STRAP),
        .busy_i      (busy),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .commit_o    (commit)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 8'hff);
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = pat(i);
    end

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr]   <= mem_wdata;
            wlog[wcnt % 16] <= mem_addr;
            wcnt            <= wcnt + 1;
        end
        if (commit) ccnt <= ccnt + 1;
        if (rst_n && (sda_oe != oe_prev) && scl_m) oe_viol <= oe_viol + 1;
        oe_prev <= sda_oe;
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic m_bit(input logic b, output logic s);
        sda_m = b;
        hold(H);
        scl_m = 1'b1;
        hold(H);
        s = sda_bus;
        scl_m = 1'b0;
        hold(2);
    endtask

    task automatic m_start();
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b1; hold(H);
    endtask

    task automatic m_wr(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_rd(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            b[i] = s;
        end
        m_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        check("R1 oe after reset", int'(sda_oe), 0);
        check("R1 we after reset", int'(mem_we), 0);
        check("R1 commit after reset", int'(commit), 0);
        check("R1 pointer after reset", int'(mem_addr), 0);
    endtask

    task automatic t_byte_write();
        logic a;
        int w0 = wcnt, c0 = ccnt;
        m_start();
        m_wr(DEV_W, a);  check("R3 device ack", int'(a), 1);
        hold(4);
        check("R11 ack released after ninth clock", int'(sda_oe), 0);
        m_wr(8'hFE, a);  check("R4 high addr ack", int'(a), 1);
        m_wr(8'h2A, a);  check("R4 low addr ack", int'(a), 1);
        m_wr(8'h5C, a);  check("R5 data ack", int'(a), 1);
        m_stop();
        hold(4);
        check("R5 one strobe", wcnt - w0, 1);
        check("R4 upper bits ignored, address", int'(wlog[w0 % 16]), 'h22A);
        check("R5 data stored", int'(mem['h22A]), 'h5C);
        check("R10 commit after write stop", ccnt - c0, 1);
    endtask

    task automatic t_page_write();
        logic a;
        int w0 = wcnt;
        m_start();
        m_wr(DEV_W, a);
        m_wr(8'h00, a);
        m_wr(8'hE6, a);
        for (int k = 0; k < 4; k++) m_wr(8'(8'h11 * (k + 1)), a);
        m_stop();
        hold(4);
        check("R5 page write count", wcnt - w0, 4);
        check("R5 page addr 0", int'(wlog[(w0 + 0) % 16]), 'h0E6);
        check("R5 page addr 1", int'(wlog[(w0 + 1) % 16]), 'h0E7);
        check("R5 page wrap addr 2", int'(wlog[(w0 + 2) % 16]), 'h0E0);
        check("R5 page wrap addr 3", int'(wlog[(w0 + 3) % 16]), 'h0E1);
        check("R5 wrapped data", int'(mem['h0E0]), 'h33);
    endtask

    task automatic t_current_read();
        logic a;
        logic [7:0] d;
        m_start();
        m_wr(DEV_R, a);  check("R6 read header ack", int'(a), 1);
        m_rd(1'b0, d);
        m_stop();
        check("R6 current address data", int'(d), int'(pat('h0E2)));
    endtask

    task automatic t_random_read();
        logic a;
        logic [7:0] d;
        int c0 = ccnt;
        m_start();
        m_wr(DEV_W, a);
        m_wr(8'h01, a);
        m_wr(8'h55, a);
        m_start();
        m_wr(DEV_R, a);  check("R7 repeated start read ack", int'(a), 1);
        m_rd(1'b0, d);
        m_stop();
        hold(4);
        check("R7 random read data", int'(d), int'(pat('h155)));
        check("R10 no commit for header only", ccnt - c0, 0);
    endtask

    task automatic t_seq_read();
        logic a;
        logic [7:0] d;
        m_start();
        m_wr(DEV_W, a);
        m_wr(8'h03, a);
        m_wr(8'hFE, a);
        m_start();
        m_wr(DEV_R, a);
        m_rd(1'b1, d);  check("R8 seq byte 0x3FE", int'(d), int'(pat('h3FE)));
        m_rd(1'b1, d);  check("R8 seq byte 0x3FF", int'(d), int'(pat('h3FF)));
        m_rd(1'b0, d);  check("R8 seq wrap to 0", int'(d), int'(pat(0)));
        hold(H);
        check("R8 released after master nack", int'(sda_oe), 0);
        m_stop();
        m_start();
        m_wr(DEV_R, a);
        m_rd(1'b0, d);
        m_stop();
        check("R6 pointer kept after wrap", int'(d), int'(pat(1)));
    endtask

    task automatic t_mismatch();
        logic a;
        int w0 = wcnt, c0 = ccnt;
        m_start();
        m_wr({4'b1010, 3'b100, 1'b0}, a);  check("R3 strap mismatch nack", int'(a), 0);
        m_wr(8'h00, a);                    check("R12 ignored after mismatch", int'(a), 0);
        m_wr(8'h10, a);                    check("R12 still ignored", int'(a), 0);
        m_stop();
        m_start();
        m_wr({4'b1011, STRAP, 1'b0}, a);   check("R3 code mismatch nack", int'(a), 0);
        m_stop();
        hold(4);
        check("R12 no strobe after mismatch", wcnt - w0, 0);
        check("R10 no commit after mismatch", ccnt - c0, 0);
    endtask

    task automatic t_busy();
        logic a;
        int w0 = wcnt, c0 = ccnt;
        busy = 1'b1;
        m_start();
        m_wr(DEV_W, a);  check("R9 no ack while busy", int'(a), 0);
        m_wr(8'h00, a);  check("R9 data ignored while busy", int'(a), 0);
        m_wr(8'h40, a);
        m_wr(8'hEE, a);
        m_stop();
        hold(4);
        check("R9 no strobe while busy", wcnt - w0, 0);
        busy = 1'b0;
        hold(4);
        m_start();
        m_wr(DEV_W, a);  check("R9 poll ack after busy", int'(a), 1);
        m_stop();
        hold(4);
        check("R10 no commit for poll", ccnt - c0, 0);
    endtask

    task automatic t_abort();
        logic a, s;
        int w0 = wcnt;
        m_start();
        m_bit(1'b1, s); m_bit(1'b0, s); m_bit(1'b1, s); m_bit(1'b0, s);
        m_start();
        m_wr(DEV_W, a);  check("R2 restart after partial byte", int'(a), 1);
        m_wr(8'h00, a);
        m_wr(8'h10, a);
        m_wr(8'h99, a);
        m_stop();
        hold(4);
        check("R2 write after abort count", wcnt - w0, 1);
        check("R2 write after abort address", int'(wlog[w0 % 16]), 'h010);
        check("R2 write after abort data", int'(mem['h010]), 'h99);
    endtask

    initial begin
        hold(5);
        rst_n = 1'b1;
        hold(5);
        t_reset();
        t_byte_write();
        t_page_write();
        t_current_read();
        t_random_read();
        t_seq_read();
        t_mismatch();
        t_busy();
        t_abort();
        check("R11 enable changed only with clock low", oe_viol, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule